// File: doc/BRIEF.md
# Byte-Serial Vector and Curve Stepper

This block drives the beam position of a vector display one dot at a time. A host loads a start position (24-bit X and Y), a per-dot step for each axis (16-bit), an optional per-dot change of that step (8-bit acceleration), a dot count and a curve-enable bit, then pulses start. For every dot the block first copies the current position to its DAC outputs with a one-cycle strobe. It then advances the position with a fixed series of byte-wide additions, all on a single shared 8-bit adder.

X is advanced before Y. Each axis is handled low byte first, and a carry flag links each byte to the next. Where an operand is narrower than its destination, the missing top bytes are filled with the operand's sign. In curve mode the steps are then advanced by the accelerations in the same byte-serial way, Y before X. The new step therefore takes effect from the next dot on.

A dot count of zero plots nothing and finishes at once. All arithmetic is two's complement and wraps at the register width without any indication.

Top module: `vstep_core`

## Requirements
- R1: After synchronous reset, busy, done and dac_strobe are 0 and dac_x and dac_y are 0.
- R2: Dot k (counting from 0) presents X0 + k*sign_extend(dx) on dac_x, and the same rule with dy on dac_y. The values change only in a cycle where dac_strobe is 1, so dot 0 shows the loaded position exactly.
- R3: Position additions carry between bytes and sign-extend the 16-bit step to 24 bits. A step with bit 15 set uses 0xFF as its top byte, so it moves the position downward, including borrows across byte boundaries.
- R4: Position arithmetic wraps modulo 2^24. For example, 0xFFFFFF plus 1 gives 0x000000.
- R5: The Y position is updated by the same rule as X and independently of X.
- R6: With curve_en set at start, each axis step grows by the sign-extended 8-bit acceleration after every dot, with wrap modulo 2^16. Dot k+1 uses the step as updated after dot k.
- R7: With curve_en clear at start, the accelerations are ignored and the steps stay constant for the whole run.
- R8: A run with count N > 0 produces exactly N strobes. It then raises done for one cycle with busy low, and busy is high from the cycle after start until done.
- R9: A start with count 0 produces no strobe. It raises done in the cycle after start, and busy stays 0.
- R10: Consecutive strobes are 8 cycles apart without curve mode and 12 cycles apart with it. dac_strobe is high only while busy.
- R11: A start pulse while busy is ignored, together with all load values presented with it, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; load inputs are captured in the same cycle when idle |
| curve_en | input | 1 | Enable per-dot step update by the accelerations |
| load_x | input | 24 | Start X position |
| load_y | input | 24 | Start Y position |
| load_dx | input | 16 | X step per dot, two's complement |
| load_dy | input | 16 | Y step per dot, two's complement |
| load_ax | input | 8 | X acceleration per dot, two's complement |
| load_ay | input | 8 | Y acceleration per dot, two's complement |
| load_count | input | 16 | Number of dots to plot |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| dac_x | output | 24 | X position of the current dot |
| dac_y | output | 24 | Y position of the current dot |
| dac_strobe | output | 1 | One-cycle pulse when dac_x and dac_y take a new dot |

## Verification
Two events can coincide in one cycle. The first is a new start request arriving while a run is still stepping. The second is the last dot's count update that ends the run. The bench provokes the first by pulsing start with different load values in the middle of a run, and judges it by checking that the strobe count and every dot still follow the first load. It probes the boundary between the two events with a zero-count start, which must produce done in the very next cycle without ever raising busy or a strobe.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Micro-sequence phases. Order of the arithmetic phases is behaviour:
    // X position, Y position, then (curve mode) Y step, X step.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DOT,
        PH_POS_X,
        PH_POS_Y,
        PH_VEL_Y,
        PH_VEL_X,
        PH_COUNT
    } phase_e;

    typedef struct packed {
        byte_t a;
        byte_t b;
        logic  cin;
    } add_req_t;

    typedef struct packed {
        byte_t sum;
        logic  cout;
    } add_rsp_t;

    // Byte used above the top of a narrower two's complement operand.
    function automatic byte_t sign_fill(input logic msb);
        return msb ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vstep_add8.sv
module vstep_add8
    import vstep_pkg::*;
(
    input  add_req_t req,
    output add_rsp_t rsp
);

    logic [BYTE_W:0] total;

    always_comb begin
        total = {1'b0, req.a} + {1'b0, req.b} + {{BYTE_W{1'b0}}, req.cin};
        rsp.sum  = total[BYTE_W-1:0];
        rsp.cout = total[BYTE_W];
    end

endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int POS_BYTES = 3,
    parameter int VEL_BYTES = 2,
    parameter int IDX_W     = $clog2(max_of(POS_BYTES, VEL_BYTES) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             zero_count,
    input  logic             curve,
    input  logic             last_dot,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             busy
);

    logic pos_last;
    logic vel_last;

    assign pos_last = (idx == IDX_W'(POS_BYTES - 1));
    assign vel_last = (idx == IDX_W'(VEL_BYTES - 1));
    assign busy     = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (zero_count) done  <= 1'b1;
                        else            phase <= PH_DOT;
                    end
                end
                PH_DOT: begin
                    phase <= PH_POS_X;
                    idx   <= '0;
                end
                PH_POS_X: begin
                    if (pos_last) begin
                        phase <= PH_POS_Y;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_POS_Y: begin
                    if (pos_last) begin
                        phase <= curve ? PH_VEL_Y : PH_COUNT;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_VEL_Y: begin
                    if (vel_last) begin
                        phase <= PH_VEL_X;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_VEL_X: begin
                    if (vel_last) begin
                        phase <= PH_COUNT;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_COUNT: begin
                    if (last_dot) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_DOT;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: the end-of-run pulse only appears once the sequencer is idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE));

    // R3: byte index never leaves the position width during position adds
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_POS_X || phase == PH_POS_Y) |-> (idx < IDX_W'(POS_BYTES)));

endmodule

// File: rtl/vstep_core.sv
module vstep_core
    import vstep_pkg::*;
#(
    parameter int POS_BYTES = 3,
    parameter int VEL_BYTES = 2,
    parameter int ACC_BYTES = 1,
    parameter int CNT_W     = 16,
    localparam int POS_W    = POS_BYTES * BYTE_W,
    localparam int VEL_W    = VEL_BYTES * BYTE_W,
    localparam int ACC_W    = ACC_BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             curve_en,
    input  logic [POS_W-1:0] load_x,
    input  logic [POS_W-1:0] load_y,
    input  logic [VEL_W-1:0] load_dx,
    input  logic [VEL_W-1:0] load_dy,
    input  logic [ACC_W-1:0] load_ax,
    input  logic [ACC_W-1:0] load_ay,
    input  logic [CNT_W-1:0] load_count,
    output logic             busy,
    output logic             done,
    output logic [POS_W-1:0] dac_x,
    output logic [POS_W-1:0] dac_y,
    output logic             dac_strobe
);

    localparam int IDX_W = $clog2(max_of(POS_BYTES, VEL_BYTES) + 1);

    // Byte-organised state registers
    logic [POS_BYTES-1:0][BYTE_W-1:0] x_q, y_q;
    logic [VEL_BYTES-1:0][BYTE_W-1:0] dx_q, dy_q;
    logic [ACC_BYTES-1:0][BYTE_W-1:0] ax_q, ay_q;
    logic [CNT_W-1:0]                 cnt_q;
    logic                             curve_q;
    logic                             carry_q;
    logic [POS_W-1:0]                 dac_x_q, dac_y_q;
    logic                             strobe_q;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             seq_busy;
    logic             seq_done;

    add_req_t req;
    add_rsp_t rsp;

    // Selected bytes for the current index
    byte_t x_b, y_b, dx_b, dy_b, dx_ext, dy_ext, ax_ext, ay_ext;
    logic  arith;

    vstep_seq #(
        .POS_BYTES (POS_BYTES),
        .VEL_BYTES (VEL_BYTES),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .zero_count (load_count == '0),
        .curve      (curve_q),
        .last_dot   (cnt_q == CNT_W'(1)),
        .phase      (phase),
        .idx        (idx),
        .done       (seq_done),
        .busy       (seq_busy)
    );

    vstep_add8 u_add (
        .req (req),
        .rsp (rsp)
    );

    // Byte selection: narrower operands are widened with their sign byte
    always_comb begin
        x_b    = '0;
        y_b    = '0;
        dx_b   = '0;
        dy_b   = '0;
        dx_ext = sign_fill(dx_q[VEL_BYTES-1][BYTE_W-1]);
        dy_ext = sign_fill(dy_q[VEL_BYTES-1][BYTE_W-1]);
        ax_ext = sign_fill(ax_q[ACC_BYTES-1][BYTE_W-1]);
        ay_ext = sign_fill(ay_q[ACC_BYTES-1][BYTE_W-1]);
        for (int i = 0; i < POS_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                x_b = x_q[i];
                y_b = y_q[i];
            end
        end
        for (int i = 0; i < VEL_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                dx_b   = dx_q[i];
                dy_b   = dy_q[i];
                dx_ext = dx_q[i];
                dy_ext = dy_q[i];
            end
        end
        for (int i = 0; i < ACC_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                ax_ext = ax_q[i];
                ay_ext = ay_q[i];
            end
        end
    end

    // Operand routing into the shared adder
    always_comb begin
        req   = '0;
        arith = 1'b1;
        case (phase)
            PH_POS_X: begin req.a = x_b;  req.b = dx_ext; end
            PH_POS_Y: begin req.a = y_b;  req.b = dy_ext; end
            PH_VEL_Y: begin req.a = dy_b; req.b = ay_ext; end
            PH_VEL_X: begin req.a = dx_b; req.b = ax_ext; end
            default:  arith = 1'b0;
        endcase
        req.cin = arith && (idx != '0) && carry_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q      <= '0;
            y_q      <= '0;
            dx_q     <= '0;
            dy_q     <= '0;
            ax_q     <= '0;
            ay_q     <= '0;
            cnt_q    <= '0;
            curve_q  <= 1'b0;
            carry_q  <= 1'b0;
            dac_x_q  <= '0;
            dac_y_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (arith) carry_q <= rsp.cout;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        x_q     <= load_x;
                        y_q     <= load_y;
                        dx_q    <= load_dx;
                        dy_q    <= load_dy;
                        ax_q    <= load_ax;
                        ay_q    <= load_ay;
                        cnt_q   <= load_count;
                        curve_q <= curve_en;
                    end
                end
                PH_DOT: begin
                    dac_x_q  <= x_q;
                    dac_y_q  <= y_q;
                    strobe_q <= 1'b1;
                end
                PH_POS_X: begin
                    for (int i = 0; i < POS_BYTES; i++)
                        if (idx == IDX_W'(i)) x_q[i] <= rsp.sum;
                end
                PH_POS_Y: begin
                    for (int i = 0; i < POS_BYTES; i++)
                        if (idx == IDX_W'(i)) y_q[i] <= rsp.sum;
                end
                PH_VEL_Y: begin
                    for (int i = 0; i < VEL_BYTES; i++)
                        if (idx == IDX_W'(i)) dy_q[i] <= rsp.sum;
                end
                PH_VEL_X: begin
                    for (int i = 0; i < VEL_BYTES; i++)
                        if (idx == IDX_W'(i)) dx_q[i] <= rsp.sum;
                end
                PH_COUNT: cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign busy       = seq_busy;
    assign done       = seq_done;
    assign dac_x      = dac_x_q;
    assign dac_y      = dac_y_q;
    assign dac_strobe = strobe_q;

    // R10: a dot is only ever emitted inside a run
    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
        dac_strobe |-> busy);

    // R2: DAC outputs move only together with the strobe
    p_dac_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ((dac_x != $past(dac_x)) || (dac_y != $past(dac_y))) |-> dac_strobe);

    // R8: the remaining dot count never grows during a run
    p_cnt_down_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));

    // R7: without curve mode the steps are frozen for the run
    p_vel_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !curve_q) |-> ($stable(dx_q) && $stable(dy_q)));

    // R9: a zero count finishes immediately without entering a run
    p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (load_count == '0)) |=> (done && !busy));

endmodule

// File: tb/tb_vstep_core.sv
module tb_vstep_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        curve_en = 1'b0;
    logic [23:0] load_x = '0, load_y = '0;
    logic [15:0] load_dx = '0, load_dy = '0;
    logic [7:0]  load_ax = '0, load_ay = '0;
    logic [15:0] load_count = '0;
    logic        busy, done, dac_strobe;
    logic [23:0] dac_x, dac_y;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [23:0] cap_x [0:63];
    logic [23:0] cap_y [0:63];
    int          cap_t [0:63];
    int          ncap = 0;

    always #4 clk = ~clk;   // 125 MHz

    vstep_core dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .curve_en   (curve_en),
        .load_x     (load_x),
        .load_y     (load_y),
        .load_dx    (load_dx),
        .load_dy    (load_dy),
        .load_ax    (load_ax),
        .load_ay    (load_ay),
        .load_count (load_count),
        .busy       (busy),
        .done       (done),
        .dac_x      (dac_x),
        .dac_y      (dac_y),
        .dac_strobe (dac_strobe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (dac_strobe && ncap < 64) begin
            cap_x[ncap] = dac_x;
            cap_y[ncap] = dac_y;
            cap_t[ncap] = cyc;
            ncap = ncap + 1;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int seen);
        int guard = 0;
        seen = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (done) seen = 1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Load, run, and compare every dot against an independent model.
    task automatic run_case(input string tag,
                            input logic [23:0] x0, input logic [23:0] y0,
                            input logic [15:0] vx0, input logic [15:0] vy0,
                            input logic [7:0] ax, input logic [7:0] ay,
                            input logic [15:0] n, input bit crv,
                            input int period, input bit disturb);
        logic [23:0] ex, ey;
        logic [15:0] vx, vy;
        int seen;
        @(negedge clk);
        load_x = x0; load_y = y0; load_dx = vx0; load_dy = vy0;
        load_ax = ax; load_ay = ay; load_count = n; curve_en = crv;
        ncap = 0;
        pulse_start();
        chk({tag, " R8 busy after start"}, busy, 1);
        if (disturb) begin
            repeat (10) @(negedge clk);
            load_x = 24'h555555; load_y = 24'hAAAAAA; load_dx = 16'h7777;
            load_dy = 16'h1111; load_count = 16'd40; curve_en = ~crv;
            pulse_start();   // R11: must be ignored while busy
        end
        wait_done(seen);
        chk({tag, " R8 done seen"}, seen, 1);
        chk({tag, " R8 busy low at done"}, busy, 0);
        chk({tag, " R8 dot count"}, ncap, n);
        ex = x0; ey = y0; vx = vx0; vy = vy0;
        for (int k = 0; k < int'(n) && k < ncap; k++) begin
            chk({tag, " R2 R3 R4 x dot"}, cap_x[k], ex);
            chk({tag, " R5 y dot"}, cap_y[k], ey);
            if (k > 0) chk({tag, " R10 dot period"}, cap_t[k] - cap_t[k-1], period);
            ex = ex + {{8{vx[15]}}, vx};
            ey = ey + {{8{vy[15]}}, vy};
            if (crv) begin
                vx = vx + {{8{ax[7]}}, ax};
                vy = vy + {{8{ay[7]}}, ay};
            end
        end
        @(negedge clk);
        chk({tag, " R8 done is one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobe", dac_strobe, 0);
        chk("R1 dac_x", dac_x, 0);
        chk("R1 dac_y", dac_y, 0);
    endtask

    task automatic t_zero_count();
        @(negedge clk);
        load_count = 16'd0; load_x = 24'h123456;
        ncap = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 done next cycle", done, 1);
        chk("R9 busy stays low", busy, 0);
        @(negedge clk);
        chk("R9 done drops", done, 0);
        chk("R9 busy still low", busy, 0);
        repeat (10) @(negedge clk);
        chk("R9 no strobe", ncap, 0);
    endtask

    initial begin
        t_reset();
        // R2 R5 R8 R10: plain line, positive steps
        run_case("line", 24'h100000, 24'h200000, 16'h0123, 16'h0040,
                 8'h00, 8'h00, 16'd5, 1'b0, 8, 1'b0);
        // R3: negative steps with borrows across bytes
        run_case("neg", 24'h000010, 24'h800000, 16'hFF00, 16'h8000,
                 8'h00, 8'h00, 16'd6, 1'b0, 8, 1'b0);
        // R3 R4: carries through all bytes and wrap at 24 bits
        run_case("wrap", 24'h00FFFF, 24'hFFFFFF, 16'h0001, 16'h0001,
                 8'h00, 8'h00, 16'd3, 1'b0, 8, 1'b0);
        // R6: curve mode with step overflow at 16 bits and negative accel
        run_case("curve", 24'h400000, 24'h400000, 16'h7FFE, 16'h0010,
                 8'h05, 8'hFD, 16'd6, 1'b1, 12, 1'b0);
        // R7: accelerations present but curve mode off
        run_case("nocurve", 24'h000100, 24'h000200, 16'h0002, 16'hFFFE,
                 8'h7F, 8'h80, 16'd5, 1'b0, 8, 1'b0);
        // R9: zero count
        t_zero_count();
        // R11: start during a run is ignored
        run_case("R11 busy start", 24'h010203, 24'h040506, 16'h0100, 16'hFF80,
                 8'h00, 8'h00, 16'd4, 1'b0, 8, 1'b1);
        finish_run();
    end

endmodule